// File: doc/BRIEF.md
# Packet-Filter VM Arithmetic Unit

This block is the integer execution unit of a 64-bit register virtual machine used for packet filtering. Each issued instruction supplies an 8-bit opcode, the current destination register value, the source register value and a 32-bit immediate. The unit returns the new destination value together with a one-cycle completion strobe and an illegal-operation flag. The register file, instruction fetch, memory access and byte-order conversion live elsewhere.

Every operation exists in a narrow form and a wide form. The narrow form works on the low halves of the operands and zero-extends the result. The wide form works on full 64-bit values and sign-extends the immediate. One opcode bit chooses whether the second operand comes from the immediate or from the source register. Unsigned division and remainder run on a restoring divider that produces one quotient bit per cycle. Every other operation completes in a single cycle.

A controller sequences the divider and the completion strobe. A datapath holds the operand logic, the divider registers and the result register. The two talk through a small bundle of strobes.

Top module: `filt_alu`

## Requirements
- R1: Opcode bits [2:0] select the operand width: 3'h4 is narrow (32-bit) and 3'h7 is wide (64-bit). Any other value in these bits raises `illegal`, and `result` is set to `dstVal` unchanged.
- R2: Opcode bit 3 chooses the second operand: 0 takes `imm`, sign-extended to 64 bits; 1 takes `srcVal`. In narrow mode both operands are cut to their low 32 bits before the operation.
- R3: Opcode bits [7:4] select the operation. 0 add; 1 subtract; 2 multiply, keeping the low bits; 4 or; 5 and; 10 xor; 11 move the second operand; 8 negate, giving the two's complement of the destination operand. The source operand is ignored for negate.
- R4: In narrow mode the 32-bit result is zero-extended to 64 bits.
- R5: Operation 6 is a left shift, 7 a logical right shift and 12 an arithmetic right shift that fills with the sign bit (bit 31 in narrow mode, bit 63 in wide mode). The shift amount is the second operand masked to 5 bits in narrow mode and to 6 bits in wide mode.
- R6: Operation 3 is unsigned divide and 9 unsigned remainder. Dividing by zero gives 0. A remainder by zero gives the destination operand itself (its low 32 bits, zero-extended, in narrow mode).
- R7: For every operation other than divide and remainder, including illegal ones, `done` is high for exactly the one cycle after the cycle in which `issue` is sampled high.
- R8: A legal divide or remainder raises `done` 33 cycles after issue in narrow mode and 65 cycles after issue in wide mode. An `issue` that arrives while a division is in progress is ignored.
- R9: Operation codes 13, 14 and 15 raise `illegal` with `done`, and `result` is set to `dstVal` unchanged.
- R10: Reset clears `result`, `done` and `illegal`. `result` and `illegal` hold their values from one `done` pulse until the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| issue | input | 1 | Start the operation described by the other inputs |
| opcode | input | 8 | Operation, operand source and width selector |
| dstVal | input | 64 | Destination register value |
| srcVal | input | 64 | Source register value |
| imm | input | 32 | Immediate operand |
| result | output | 64 | New destination value, valid while `done` is high and held afterwards |
| done | output | 1 | One-cycle completion strobe |
| illegal | output | 1 | The completed operation was not a legal arithmetic opcode |

## Verification
The assertions take for granted that `opcode` and the operands hold known values in any cycle where `issue` is high. They also assume that the caller treats a pending division as busy. The latency and value properties therefore apply only to an issue accepted while no division is in flight. The stimulus issues one operation and waits for its completion strobe before starting the next. The one exception is a single deliberate issue placed during a wide division, which tests that the unit ignores it. The sweep covers every opcode value in all eight width-field settings and both operand sources. It uses operand patterns chosen to hit zero divisors, sign bits and shift amounts beyond the narrow mask.

// File: rtl/filt_alu_pkg.sv
package filt_alu_pkg;

  localparam logic [2:0] CLS_NARROW = 3'h4;
  localparam logic [2:0] CLS_WIDE   = 3'h7;

  localparam logic [3:0] OP_ADD = 4'h0;
  localparam logic [3:0] OP_SUB = 4'h1;
  localparam logic [3:0] OP_MUL = 4'h2;
  localparam logic [3:0] OP_DIV = 4'h3;
  localparam logic [3:0] OP_OR  = 4'h4;
  localparam logic [3:0] OP_AND = 4'h5;
  localparam logic [3:0] OP_SHL = 4'h6;
  localparam logic [3:0] OP_SHR = 4'h7;
  localparam logic [3:0] OP_NEG = 4'h8;
  localparam logic [3:0] OP_MOD = 4'h9;
  localparam logic [3:0] OP_XOR = 4'ha;
  localparam logic [3:0] OP_MOV = 4'hb;
  localparam logic [3:0] OP_SAR = 4'hc;

  typedef struct packed {
    logic [3:0] op;
    logic       useReg;
    logic       wide;
    logic       illegal;
    logic       isDiv;
  } decodeT;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic finishNow;
    logic divLoad;
    logic divStep;
    logic divLast;
  } strobeT;

  function automatic decodeT decodeOp(input logic [7:0] opc);
    decodeT d;
    d.op      = opc[7:4];
    d.useReg  = opc[3];
    d.wide    = (opc[2:0] == CLS_WIDE);
    d.illegal = !((opc[2:0] == CLS_NARROW) || (opc[2:0] == CLS_WIDE)) || (opc[7:4] > OP_SAR);
    d.isDiv   = !d.illegal && ((opc[7:4] == OP_DIV) || (opc[7:4] == OP_MOD));
    return d;
  endfunction

endpackage

// File: rtl/filt_alu_ctrl.sv
module filt_alu_ctrl
  import filt_alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   issue,
  input  logic   isDiv,
  input  logic   isIllegal,
  input  logic   wide,
  output strobeT stb,
  output logic   busy,
  output logic   done,
  output logic   illegal
);
  localparam int HALF = XLEN / 2;
  localparam int CW   = $clog2(XLEN + 1);

  logic          busyQ;
  logic [CW-1:0] cnt;
  logic          accept;

  always_comb begin
    accept        = issue && !busyQ;
    stb.finishNow = accept && !isDiv;
    stb.divLoad   = accept && isDiv;
    stb.divStep   = busyQ;
    stb.divLast   = busyQ && (cnt == CW'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      cnt   <= '0;
    end else if (stb.divLoad) begin
      busyQ <= 1'b1;
      cnt   <= wide ? CW'(XLEN) : CW'(HALF);
    end else if (busyQ) begin
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) busyQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done <= stb.finishNow || stb.divLast;
      if (stb.finishNow)    illegal <= isIllegal;
      else if (stb.divLast) illegal <= 1'b0;
    end
  end

  assign busy = busyQ;

endmodule

// File: rtl/filt_alu_dp.sv
module filt_alu_dp
  import filt_alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobeT          stb,
  input  logic [3:0]      op,
  input  logic            useReg,
  input  logic            wide,
  input  logic            isIllegal,
  input  logic [XLEN-1:0] dstVal,
  input  logic [XLEN-1:0] srcVal,
  input  logic [XLEN/2-1:0] imm,
  output logic [XLEN-1:0] result
);
  localparam int HALF = XLEN / 2;
  localparam int SHW  = $clog2(XLEN);

  logic [XLEN-1:0] opA, opB, rawB, sarSrc, aluRaw, aluOut;
  logic [SHW-1:0]  shAmt;

  // operand selection and narrowing
  always_comb begin
    opA    = wide ? dstVal : {{HALF{1'b0}}, dstVal[HALF-1:0]};
    rawB   = useReg ? srcVal : {{HALF{imm[HALF-1]}}, imm};
    opB    = wide ? rawB : {{HALF{1'b0}}, rawB[HALF-1:0]};
    shAmt  = wide ? opB[SHW-1:0] : {1'b0, opB[SHW-2:0]};
    sarSrc = wide ? opA : {{HALF{opA[HALF-1]}}, opA[HALF-1:0]};
  end

  always_comb begin
    case (op)
      OP_ADD:  aluRaw = opA + opB;
      OP_SUB:  aluRaw = opA - opB;
      OP_MUL:  aluRaw = opA * opB;
      OP_OR:   aluRaw = opA | opB;
      OP_AND:  aluRaw = opA & opB;
      OP_SHL:  aluRaw = opA << shAmt;
      OP_SHR:  aluRaw = opA >> shAmt;
      OP_NEG:  aluRaw = '0 - opA;
      OP_XOR:  aluRaw = opA ^ opB;
      OP_MOV:  aluRaw = opB;
      OP_SAR:  aluRaw = $signed(sarSrc) >>> shAmt;
      default: aluRaw = '0;
    endcase
    aluOut = wide ? aluRaw : {{HALF{1'b0}}, aluRaw[HALF-1:0]};
  end

  // restoring divider, one quotient bit per step
  logic [XLEN-1:0] remQ, quoQ, divisorQ;
  logic            isModQ, divZeroQ;
  logic [XLEN:0]   remShift;
  logic            fits;
  logic [XLEN-1:0] remNext, quoNext;

  always_comb begin
    remShift = {remQ, quoQ[XLEN-1]};
    fits     = remShift >= {1'b0, divisorQ};
    remNext  = fits ? (remShift[XLEN-1:0] - divisorQ) : remShift[XLEN-1:0];
    quoNext  = {quoQ[XLEN-2:0], fits};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remQ     <= '0;
      quoQ     <= '0;
      divisorQ <= '0;
      isModQ   <= 1'b0;
      divZeroQ <= 1'b0;
    end else if (stb.divLoad) begin
      remQ     <= '0;
      quoQ     <= wide ? opA : {opA[HALF-1:0], {HALF{1'b0}}};
      divisorQ <= opB;
      isModQ   <= (op == OP_MOD);
      divZeroQ <= (opB == '0);
    end else if (stb.divStep) begin
      remQ <= remNext;
      quoQ <= quoNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              result <= '0;
    else if (stb.finishNow) result <= isIllegal ? dstVal : aluOut;
    else if (stb.divLast)   result <= isModQ ? remNext : (divZeroQ ? '0 : quoNext);
  end

endmodule

// File: rtl/filt_alu.sv
module filt_alu
  import filt_alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issue,
  input  logic [7:0]        opcode,
  input  logic [XLEN-1:0]   dstVal,
  input  logic [XLEN-1:0]   srcVal,
  input  logic [XLEN/2-1:0] imm,
  output logic [XLEN-1:0]   result,
  output logic              done,
  output logic              illegal
);
  decodeT dec;
  strobeT stb;
  logic   busy;

  assign dec = decodeOp(opcode);

  filt_alu_ctrl #(.XLEN(XLEN)) i_ctrl (
    .clk(clk), .rstN(rstN), .issue(issue),
    .isDiv(dec.isDiv), .isIllegal(dec.illegal), .wide(dec.wide),
    .stb(stb), .busy(busy), .done(done), .illegal(illegal)
  );

  filt_alu_dp #(.XLEN(XLEN)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .op(dec.op), .useReg(dec.useReg), .wide(dec.wide), .isIllegal(dec.illegal),
    .dstVal(dstVal), .srcVal(srcVal), .imm(imm), .result(result)
  );

endmodule

// File: rtl/filt_alu_chk.sv
module filt_alu_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rstN,
  input logic            issue,
  input logic [7:0]      opcode,
  input logic [XLEN-1:0] dstVal,
  input logic [XLEN-1:0] srcVal,
  input logic [XLEN-1:0] result,
  input logic            done,
  input logic            illegal,
  input logic            busy
);
  localparam int HALF = XLEN / 2;

  logic legalCls, divOp;
  assign legalCls = (opcode[2:0] == 3'h4) || (opcode[2:0] == 3'h7);
  assign divOp    = (opcode[7:4] == 4'h3) || (opcode[7:4] == 4'h9);

  p_single_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    (issue && !busy && !divOp) |=> done);

  p_div_wait_r8: assert property (@(posedge clk) disable iff (!rstN)
    (issue && !busy && divOp && legalCls) |=> (!done && busy));

  p_illegal_keeps_dst_r9: assert property (@(posedge clk) disable iff (!rstN)
    (done && illegal) |-> ($past(issue) && result == $past(dstVal)));

  p_narrow_zext_r4: assert property (@(posedge clk) disable iff (!rstN)
    (issue && !busy && opcode[2:0] == 3'h4 && opcode[7:4] < 4'hd && !divOp)
      |=> (result[XLEN-1:HALF] == '0));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(result) && $stable(illegal)));

  p_mov_reg_r3: assert property (@(posedge clk) disable iff (!rstN)
    (issue && !busy && opcode == 8'hbf) |=> (result == $past(srcVal)));

endmodule

bind filt_alu filt_alu_chk #(.XLEN(XLEN)) i_filt_alu_chk (
  .clk(clk), .rstN(rstN), .issue(issue), .opcode(opcode),
  .dstVal(dstVal), .srcVal(srcVal), .result(result),
  .done(done), .illegal(illegal), .busy(busy)
);

// File: tb/test_filt_alu.sv
`timescale 1ns/1ps
module test_filt_alu;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issue = 1'b0;
  logic [7:0]  opcode = '0;
  logic [63:0] dstVal = '0, srcVal = '0;
  logic [31:0] imm = '0;
  logic [63:0] result;
  logic        done, illegal;

  int nChecks = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  filt_alu i_filt_alu (
    .clk(clk), .rstN(rstN), .issue(issue), .opcode(opcode),
    .dstVal(dstVal), .srcVal(srcVal), .imm(imm),
    .result(result), .done(done), .illegal(illegal)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s op=%h: actual %h expected %h", tag, opcode, act, exp);
    end
  endtask

  function automatic void pattern(input int i, output logic [63:0] d, output logic [63:0] s, output logic [31:0] im);
    case (i)
      0: begin d = 64'h0123456789abcdef; s = 64'h10;                 im = 32'h5;        end
      1: begin d = 64'hfedcba9876543210; s = 64'h3f;                 im = 32'hffffff81; end
      2: begin d = 64'h8000000080000000; s = 64'h21;                 im = 32'h24;       end
      3: begin d = 64'hffffffffffffffff; s = 64'h0;                  im = 32'h0;        end
      4: begin d = 64'h123456789abcdef0; s = 64'h1234;               im = 32'h7fffffff; end
      5: begin d = 64'h7;                s = 64'hfffffffffffffff9;   im = 32'h80000000; end
      6: begin d = 64'h7fffffff7fffffff; s = 64'h0000000100000000;   im = 32'h3;        end
      default: begin d = 64'ha5a5a5a55a5a5a5a; s = 64'h3c3c3c3cc3c3c3c3; im = 32'h1f; end
    endcase
  endfunction

  // reference behaviour derived from the requirements
  function automatic void model(input logic [7:0] opc, input logic [63:0] d, input logic [63:0] s,
                                input logic [31:0] im, output logic [63:0] r, output bit ill, output int lat);
    logic [3:0]  op;
    bit          wideM, legal;
    logic [63:0] a, b;
    logic [31:0] a32, b32, r32;
    op    = opc[7:4];
    wideM = (opc[2:0] == 3'h7);
    legal = (opc[2:0] == 3'h4 || wideM) && op <= 4'hc;
    ill   = !legal;
    b     = opc[3] ? s : {{32{im[31]}}, im};
    a     = d;
    a32   = d[31:0];
    b32   = b[31:0];
    r     = '0;
    lat   = 1;
    if (!legal) begin
      r = d;
      return;
    end
    if (op == 4'h3 || op == 4'h9) lat = wideM ? 65 : 33;
    if (wideM) begin
      case (op)
        4'h0: r = a + b;
        4'h1: r = a - b;
        4'h2: r = a * b;
        4'h3: r = (b == 0) ? 64'h0 : a / b;
        4'h4: r = a | b;
        4'h5: r = a & b;
        4'h6: r = a << b[5:0];
        4'h7: r = a >> b[5:0];
        4'h8: r = ~a + 64'h1;
        4'h9: r = (b == 0) ? a : a % b;
        4'ha: r = a ^ b;
        4'hb: r = b;
        default: r = $signed(a) >>> b[5:0];
      endcase
    end else begin
      case (op)
        4'h0: r32 = a32 + b32;
        4'h1: r32 = a32 - b32;
        4'h2: r32 = a32 * b32;
        4'h3: r32 = (b32 == 0) ? 32'h0 : a32 / b32;
        4'h4: r32 = a32 | b32;
        4'h5: r32 = a32 & b32;
        4'h6: r32 = a32 << b32[4:0];
        4'h7: r32 = a32 >> b32[4:0];
        4'h8: r32 = ~a32 + 32'h1;
        4'h9: r32 = (b32 == 0) ? a32 : a32 % b32;
        4'ha: r32 = a32 ^ b32;
        4'hb: r32 = b32;
        default: r32 = $signed(a32) >>> b32[4:0];
      endcase
      r = {32'h0, r32};
    end
  endfunction

  function automatic string valTag(input logic [7:0] opc);
    bit wideM = (opc[2:0] == 3'h7);
    if (!(opc[2:0] == 3'h4 || wideM)) return "R1";
    if (opc[7:4] > 4'hc) return "R9";
    if (opc[7:4] == 4'h3 || opc[7:4] == 4'h9) return "R6";
    if (opc[7:4] == 4'h6 || opc[7:4] == 4'h7 || opc[7:4] == 4'hc) return "R5";
    if (!wideM) return "R4";
    if (!opc[3]) return "R2";
    return "R3";
  endfunction

  task automatic runOp(input logic [7:0] opc, input logic [63:0] d, input logic [63:0] s, input logic [31:0] im);
    logic [63:0] expR;
    bit          expIll;
    int          expLat, lat;
    model(opc, d, s, im, expR, expIll, expLat);
    @(negedge clk);
    issue = 1'b1; opcode = opc; dstVal = d; srcVal = s; imm = im;
    @(negedge clk);
    issue = 1'b0;
    lat = 1;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == expLat, (expLat == 1) ? "R7 latency" : "R8 latency", 64'(lat), 64'(expLat));
    chk(result == expR, valTag(opc), result, expR);
    chk(illegal == expIll, expIll ? "R9/R1 flag" : "R9 flag clear", 64'(illegal), 64'(expIll));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] d, s, held;
    logic [31:0] im;
    int          lat;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(done == 1'b0, "R10 reset done", 64'(done), 64'h0);
    chk(illegal == 1'b0, "R10 reset illegal", 64'(illegal), 64'h0);
    chk(result == 64'h0, "R10 reset result", result, 64'h0);
    rstN = 1'b1;
    @(negedge clk);

    // full sweep over legal widths
    for (int c = 4; c < 8; c += 3)
      for (int op = 0; op < 16; op++)
        for (int sr = 0; sr < 2; sr++)
          for (int p = 0; p < 8; p++) begin
            pattern(p, d, s, im);
            runOp({4'(op), 1'(sr), 3'(c)}, d, s, im);
          end

    // illegal width field values
    for (int c = 0; c < 8; c++) begin
      if (c == 4 || c == 7) continue;
      for (int op = 0; op < 16; op++)
        for (int sr = 0; sr < 2; sr++) begin
          pattern(op % 8, d, s, im);
          runOp({4'(op), 1'(sr), 3'(c)}, d, s, im);
        end
    end

    // R10: result and flag hold while idle
    runOp(8'hd7, 64'h1122334455667788, 64'h0, 32'h0);
    held = result;
    repeat (4) @(negedge clk);
    chk(done == 1'b0, "R10 idle done", 64'(done), 64'h0);
    chk(result == held, "R10 hold result", result, held);
    chk(illegal == 1'b1, "R10 hold illegal", 64'(illegal), 64'h1);

    // R8: issue during a wide division is ignored
    @(negedge clk);
    issue = 1'b1; opcode = 8'h3f; dstVal = 64'd1000; srcVal = 64'd7; imm = 32'h0;
    @(negedge clk);
    opcode = 8'h07; dstVal = 64'd5; imm = 32'd9;
    lat = 1;
    @(negedge clk);
    issue = 1'b0;
    lat++;
    chk(done == 1'b0, "R8 ignored issue done", 64'(done), 64'h0);
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 65, "R8 busy latency", 64'(lat), 64'd65);
    chk(result == 64'd142, "R8 busy result", result, 64'd142);
    @(negedge clk);
    chk(done == 1'b0, "R8 single done", 64'(done), 64'h0);

    summary();
    $finish;
  end

endmodule